// File: doc/BRIEF.md
# Clock Configuration Register Unit

This block keeps the clock settings of a small system-on-chip in a set of software-visible registers on a 32-bit register bus with 12-bit offsets. One core control word sets the divide ratios of six system clock branches: CPU, high-speed bus, peripheral, memory, USB and display. It also picks the pre-divider of the PLL path and the sources of the USB and audio-serial clocks. A PLL control word gives the multiply factor, the output divider and the bypass state. Several small divider registers set the audio-serial, memory-card, pixel, USB-host and serial-peripheral clocks.

Five of the branch divider fields are 4-bit indices into a fixed, non-linear ratio table. The display divider is taken as a plain number. The unit drives every decoded ratio as an output. For each branch it also produces a one-cycle enable strobe from the reference clock (`clk`), which downstream logic can use to gate its registers. A bus front end built as a two-state machine, BUS_IDLE and BUS_RDATA, accepts single-cycle writes and answers reads one cycle later. The transitions are:

- BUS_IDLE to BUS_RDATA on a read request.
- BUS_RDATA back to BUS_IDLE when no read follows.
- BUS_RDATA to BUS_RDATA on back-to-back reads.

An access to any offset not listed below sets a sticky error flag.

Top module: `clkcfg_unit`

## Requirements
- R1: After reset the registers read as follows: core 0x42040000 (offset 0x000), PLL 0x28080011 (0x010), audio divider 0x4 (0x020), pixel divider 0x4 (0x024), card divider 0x4 (0x028), USB-host divider 0x4 (0x02C), USB test 0x0 (0x030), serial divider 0x4 (0x034), error 0x0 (0x03C).
- R2: Writes keep only these bits: core 0x53FFFFFF, PLL 0xFF0C0013, pixel 0x7FF, USB test 0x3F, and bits 3:0 of the audio, card, USB-host and serial divider registers.
- R3: The core fields [3:0] CPU, [7:4] high-speed bus, [11:8] peripheral, [15:12] memory and [24:21] USB index the table 1,2,3,4,6,8,12,16,24,32 for indices 0 to 9. Indices 10 to 15 give 32. The six ratios appear on `branch_ratio` in 6-bit slices in this order: CPU, bus, peripheral, memory, USB, display.
- R4: The display ratio equals core bits [20:16] as a plain number.
- R5: Core bit 30 set gives a PLL pre-divide of 1 and clear gives 2 (`pll_halve` is 1 when clear). Bit 28 set routes the USB clock from the PLL path, and bit 25 does the same for the audio-serial clock. A clear bit selects the external oscillator.
- R6: The PLL counts as bypassed when PLL bit 0 (enable) is clear or bit 1 (bypass) is set. Then `pll_ratio` is 1, `pll_bypass` is 1, and the stored bit 4 (stable) is forced to 1.
- R7: When the PLL is not bypassed, `pll_ratio` = (bits[31:24] + 2) × F, where F is 1, 2, 2 or 4 for bits [19:18] = 0, 1, 2 or 3.
- R8: `aud_ratio` and `card_ratio` equal their 4-bit divider field plus one.
- R9: A read request (valid with write-enable low) yields `bus_rvalid` and the data on the next cycle only.
- R10: An undecoded offset reads as 0, its writes change no register, and it sets `err_flag`. The flag stays set until a write to offset 0x03C, and it reads back as bit 0 there.
- R11: Each branch strobe is high for one cycle in every R reference cycles, where R is the branch ratio. A ratio of 0 acts as 1.
- R12: A ratio change takes effect only after the current strobe period completes, so no period is shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| err_flag | output | 1 | Sticky undecoded-access flag |
| branch_ratio | output | 36 | Six 6-bit branch ratios |
| branch_en | output | 6 | Per-branch enable strobes |
| pll_ratio | output | 11 | PLL output multiply ratio |
| pll_bypass | output | 1 | PLL bypassed |
| pll_halve | output | 1 | PLL path pre-divides by 2 |
| usb_src_pll | output | 1 | USB clock taken from PLL path |
| aud_src_pll | output | 1 | Audio-serial clock taken from PLL path |
| aud_ratio | output | 5 | Audio-serial divide ratio |
| card_ratio | output | 5 | Memory-card divide ratio |

## Verification
On every cycle, the assertions check the read-response timing of the bus state machine, the stickiness of the error flag, the unity ratio while the PLL is bypassed, a ratio of at least 2 when it is not, and the legal ranges of the divider ratios. The bench scenarios are needed for the rest:

- the exact masks and reset words;
- the table lookups and their saturation;
- the PLL product;
- strobe spacing;
- the rule that a ratio change waits for the current period to end.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int RW     = 6;
    localparam int NBR    = 6;
    localparam int NTAB   = 5;
    localparam int PLLRW  = 11;

    localparam logic [AW-1:0] OFS_CORE = 12'h000;
    localparam logic [AW-1:0] OFS_PLL  = 12'h010;
    localparam logic [AW-1:0] OFS_AUD  = 12'h020;
    localparam logic [AW-1:0] OFS_PIX  = 12'h024;
    localparam logic [AW-1:0] OFS_CARD = 12'h028;
    localparam logic [AW-1:0] OFS_UHC  = 12'h02C;
    localparam logic [AW-1:0] OFS_TST  = 12'h030;
    localparam logic [AW-1:0] OFS_SSI  = 12'h034;
    localparam logic [AW-1:0] OFS_ERR  = 12'h03C;

    localparam logic [DW-1:0] RST_CORE = 32'h4204_0000;
    localparam logic [DW-1:0] RST_PLL  = 32'h2808_0011;
    localparam logic [DW-1:0] RST_DIV  = 32'h0000_0004;

    localparam logic [DW-1:0] MSK_CORE = 32'h53FF_FFFF;
    localparam logic [DW-1:0] MSK_PLL  = 32'hFF0C_0013;
    localparam logic [DW-1:0] MSK_PIX  = 32'h0000_07FF;
    localparam logic [DW-1:0] MSK_TST  = 32'h0000_003F;
    localparam logic [DW-1:0] MSK_NIB  = 32'h0000_000F;

    localparam int PLL_STABLE_BIT = 4;

    typedef enum logic {BUS_IDLE, BUS_RDATA} bus_state_t;

    typedef struct packed {
        logic [NTAB-1:0][3:0] br_idx;
        logic [4:0]           disp_raw;
        logic                 pll_full;
        logic                 usb_sel;
        logic                 aud_sel;
        logic [7:0]           pll_n;
        logic [1:0]           pll_od;
        logic                 pll_en;
        logic                 pll_byp;
        logic [3:0]           aud_div;
        logic [3:0]           card_div;
    } cfg_t;

    function automatic logic [RW-1:0] ratio_lookup(input logic [3:0] idx);
        unique case (idx)
            4'd0:    ratio_lookup = 6'd1;
            4'd1:    ratio_lookup = 6'd2;
            4'd2:    ratio_lookup = 6'd3;
            4'd3:    ratio_lookup = 6'd4;
            4'd4:    ratio_lookup = 6'd6;
            4'd5:    ratio_lookup = 6'd8;
            4'd6:    ratio_lookup = 6'd12;
            4'd7:    ratio_lookup = 6'd16;
            4'd8:    ratio_lookup = 6'd24;
            default: ratio_lookup = 6'd32;
        endcase
    endfunction

    function automatic logic [2:0] od_factor(input logic [1:0] od);
        unique case (od)
            2'd0:    od_factor = 3'd1;
            2'd1,
            2'd2:    od_factor = 3'd2;
            default: od_factor = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_rvalid,
    output logic [DW-1:0] bus_rdata,
    output logic          err_flag,
    output cfg_t          cfg
);
    bus_state_t    state_q, state_d;
    logic [DW-1:0] core_q, pll_q, aud_q, pix_q, card_q, uhc_q, tst_q, ssi_q;
    logic          err_q;
    logic [DW-1:0] rdata_q, rd_mux;
    logic          hit, wr, rd;
    logic [DW-1:0] pll_wval;
    logic          pll_wbyp;

    assign wr = bus_valid &&  bus_we;
    assign rd = bus_valid && !bus_we;

    always_comb begin
        hit    = 1'b1;
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CORE: rd_mux = core_q;
            OFS_PLL:  rd_mux = pll_q;
            OFS_AUD:  rd_mux = aud_q;
            OFS_PIX:  rd_mux = pix_q;
            OFS_CARD: rd_mux = card_q;
            OFS_UHC:  rd_mux = uhc_q;
            OFS_TST:  rd_mux = tst_q;
            OFS_SSI:  rd_mux = ssi_q;
            OFS_ERR:  rd_mux = {{(DW-1){1'b0}}, err_q};
            default:  hit    = 1'b0;
        endcase
    end

    always_comb begin
        pll_wval = bus_wdata & MSK_PLL;
        pll_wbyp = !pll_wval[0] || pll_wval[1];
        if (pll_wbyp) pll_wval[PLL_STABLE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= RST_CORE;
            pll_q  <= RST_PLL;
            aud_q  <= RST_DIV;
            pix_q  <= RST_DIV;
            card_q <= RST_DIV;
            uhc_q  <= RST_DIV;
            tst_q  <= '0;
            ssi_q  <= RST_DIV;
        end else if (wr) begin
            unique case (bus_addr)
                OFS_CORE: core_q <= bus_wdata & MSK_CORE;
                OFS_PLL:  pll_q  <= pll_wval;
                OFS_AUD:  aud_q  <= bus_wdata & MSK_NIB;
                OFS_PIX:  pix_q  <= bus_wdata & MSK_PIX;
                OFS_CARD: card_q <= bus_wdata & MSK_NIB;
                OFS_UHC:  uhc_q  <= bus_wdata & MSK_NIB;
                OFS_TST:  tst_q  <= bus_wdata & MSK_TST;
                OFS_SSI:  ssi_q  <= bus_wdata & MSK_NIB;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (bus_valid && !hit)              err_q <= 1'b1;
        else if (wr && bus_addr == OFS_ERR)      err_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (rd)  state_d = BUS_RDATA;
            BUS_RDATA: if (!rd) state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= hit ? rd_mux : '0;
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RDATA);
        bus_rdata  = bus_rvalid ? rdata_q : '0;
        err_flag   = err_q;
    end

    always_comb begin
        cfg.br_idx[0] = core_q[3:0];
        cfg.br_idx[1] = core_q[7:4];
        cfg.br_idx[2] = core_q[11:8];
        cfg.br_idx[3] = core_q[15:12];
        cfg.br_idx[4] = core_q[24:21];
        cfg.disp_raw  = core_q[20:16];
        cfg.aud_sel   = core_q[25];
        cfg.usb_sel   = core_q[28];
        cfg.pll_full  = core_q[30];
        cfg.pll_n     = pll_q[31:24];
        cfg.pll_od    = pll_q[19:18];
        cfg.pll_en    = pll_q[0];
        cfg.pll_byp   = pll_q[1];
        cfg.aud_div   = aud_q[3:0];
        cfg.card_div  = card_q[3:0];
    end
endmodule

// File: rtl/clkcfg_ratio_map.sv
module clkcfg_ratio_map
    import clkcfg_pkg::*;
(
    input  cfg_t                  cfg,
    output logic [NBR*RW-1:0]     branch_ratio,
    output logic [PLLRW-1:0]      pll_ratio,
    output logic                  pll_bypass,
    output logic                  pll_halve,
    output logic                  usb_src_pll,
    output logic                  aud_src_pll,
    output logic [4:0]            aud_ratio,
    output logic [4:0]            card_ratio
);
    genvar g;
    generate
        for (g = 0; g < NTAB; g++) begin : g_tab
            assign branch_ratio[g*RW +: RW] = ratio_lookup(cfg.br_idx[g]);
        end
    endgenerate
    assign branch_ratio[NTAB*RW +: RW] = {{(RW-5){1'b0}}, cfg.disp_raw};

    always_comb begin
        pll_bypass = !cfg.pll_en || cfg.pll_byp;
        if (pll_bypass)
            pll_ratio = PLLRW'(1);
        else
            pll_ratio = (PLLRW'(cfg.pll_n) + PLLRW'(2)) * PLLRW'(od_factor(cfg.pll_od));
        pll_halve   = !cfg.pll_full;
        usb_src_pll = cfg.usb_sel;
        aud_src_pll = cfg.aud_sel;
        aud_ratio   = {1'b0, cfg.aud_div} + 5'd1;
        card_ratio  = {1'b0, cfg.card_div} + 5'd1;
    end
endmodule

// File: rtl/clkcfg_strobe.sv
module clkcfg_strobe
    import clkcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio,
    output logic          en
);
    logic [RW-1:0] cnt_q, act_q, eff;

    assign eff = (ratio == '0) ? RW'(1) : ratio;
    assign en  = (cnt_q == act_q - RW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= RW'(1);
        end else if (en) begin
            cnt_q <= '0;
            act_q <= eff;
        end else begin
            cnt_q <= cnt_q + RW'(1);
        end
    end
endmodule

// File: rtl/clkcfg_unit.sv
module clkcfg_unit
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              err_flag,
    output logic [35:0]       branch_ratio,
    output logic [5:0]        branch_en,
    output logic [10:0]       pll_ratio,
    output logic              pll_bypass,
    output logic              pll_halve,
    output logic              usb_src_pll,
    output logic              aud_src_pll,
    output logic [4:0]        aud_ratio,
    output logic [4:0]        card_ratio
);
    cfg_t cfg;

    clkcfg_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .err_flag   (err_flag),
        .cfg        (cfg)
    );

    clkcfg_ratio_map u_map (
        .cfg          (cfg),
        .branch_ratio (branch_ratio),
        .pll_ratio    (pll_ratio),
        .pll_bypass   (pll_bypass),
        .pll_halve    (pll_halve),
        .usb_src_pll  (usb_src_pll),
        .aud_src_pll  (aud_src_pll),
        .aud_ratio    (aud_ratio),
        .card_ratio   (card_ratio)
    );

    genvar b;
    generate
        for (b = 0; b < NBR; b++) begin : g_br
            clkcfg_strobe u_strobe (
                .clk   (clk),
                .rst_n (rst_n),
                .ratio (branch_ratio[b*RW +: RW]),
                .en    (branch_en[b])
            );
        end
    endgenerate
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic        bus_rvalid,
    input logic        err_flag,
    input logic [35:0] branch_ratio,
    input logic [10:0] pll_ratio,
    input logic        pll_bypass,
    input logic [4:0]  aud_ratio,
    input logic [4:0]  card_ratio
);
    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> bus_rvalid);

    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> !bus_rvalid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(bus_valid && bus_we && bus_addr == 12'h03C)) |=> err_flag);

    // R6
    bypass_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (pll_ratio == 11'd1));

    // R7
    active_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_bypass |-> (pll_ratio >= 11'd2));

    // R8
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_ratio != 5'd0) && (card_ratio != 5'd0) && (aud_ratio <= 5'd16));

    // R3
    table_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_ratio[5:0] != 6'd0) && (branch_ratio[5:0] <= 6'd32) &&
        (branch_ratio[29:24] != 6'd0) && (branch_ratio[29:24] <= 6'd32));
endmodule

bind clkcfg_unit clkcfg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rvalid   (bus_rvalid),
    .err_flag     (err_flag),
    .branch_ratio (branch_ratio),
    .pll_ratio    (pll_ratio),
    .pll_bypass   (pll_bypass),
    .aud_ratio    (aud_ratio),
    .card_ratio   (card_ratio)
);

// File: tb/clkcfg_unit_tb.sv
module clkcfg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        err_flag;
    logic [35:0] branch_ratio;
    logic [5:0]  branch_en;
    logic [10:0] pll_ratio;
    logic        pll_bypass, pll_halve, usb_src_pll, aud_src_pll;
    logic [4:0]  aud_ratio, card_ratio;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    clkcfg_unit u_dut (.*);

    // {offset, write data, expected readback}
    localparam logic [75:0] VEC [10] = '{
        {12'h000, 32'hFFFF_FFFF, 32'h53FF_FFFF},   // R2 core mask
        {12'h010, 32'h0000_0001, 32'h0000_0001},   // R2 R7 active, stable bit stays clear
        {12'h010, 32'h0000_0003, 32'h0000_0013},   // R6 bypass forces stable
        {12'h010, 32'h0000_0000, 32'h0000_0010},   // R6 disabled forces stable
        {12'h020, 32'hFFFF_FFF7, 32'h0000_0007},   // R2 audio
        {12'h028, 32'h0000_0123, 32'h0000_0003},   // R2 card
        {12'h024, 32'hFFFF_FFFF, 32'h0000_07FF},   // R2 pixel
        {12'h02C, 32'h0000_00FF, 32'h0000_000F},   // R2 usb host
        {12'h030, 32'hFFFF_FFFF, 32'h0000_003F},   // R2 test
        {12'h034, 32'h0000_00AB, 32'h0000_000B}    // R2 serial
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        if (!bus_rvalid) begin
            n_chk++; n_bad++;
            $display("FAIL R9 actual=rvalid 0 expected=rvalid 1");
        end
        d = bus_rdata;
    endtask

    task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic gap(input int idx, output int p);
        while (!branch_en[idx]) @(negedge clk);
        p = 0;
        do begin @(negedge clk); p++; end while (!branch_en[idx]);
    endtask

    function automatic logic [5:0] tab(input int i);
        case (i)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
            5: return 8;  6: return 12; 7: return 16; 8: return 24; default: return 32;
        endcase
    endfunction

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and derived outputs
        check("R9 idle rvalid", {31'b0, bus_rvalid}, 32'h0);
        read_chk("R1 core",  12'h000, 32'h4204_0000);
        read_chk("R1 pll",   12'h010, 32'h2808_0011);
        read_chk("R1 aud",   12'h020, 32'h4);
        read_chk("R1 pix",   12'h024, 32'h4);
        read_chk("R1 card",  12'h028, 32'h4);
        read_chk("R1 uhc",   12'h02C, 32'h4);
        read_chk("R1 tst",   12'h030, 32'h0);
        read_chk("R1 ssi",   12'h034, 32'h4);
        read_chk("R1 err",   12'h03C, 32'h0);
        check("R7 reset pll ratio", {21'b0, pll_ratio}, 32'd84);
        check("R5 reset selects", {28'b0, pll_bypass, pll_halve, usb_src_pll, aud_src_pll}, 32'b0001);
        check("R4 reset display", {26'b0, branch_ratio[35:30]}, 32'd4);
        check("R8 reset aud", {27'b0, aud_ratio}, 32'd5);

        // table walk
        for (int i = 0; i < 10; i++) begin
            logic [31:0] d;
            bus_write(VEC[i][75:64], VEC[i][63:32]);
            bus_read(VEC[i][75:64], d);
            check("R2 vector", d, VEC[i][31:0]);
        end

        // R3 R4 R5 branch lookups and selects
        bus_write(12'h000, 32'h10C7_2F49);
        check("R3 cpu",  {26'b0, branch_ratio[5:0]},   {26'b0, tab(9)});
        check("R3 bus",  {26'b0, branch_ratio[11:6]},  {26'b0, tab(4)});
        check("R3 per saturate", {26'b0, branch_ratio[17:12]}, 32'd32);
        check("R3 mem",  {26'b0, branch_ratio[23:18]}, {26'b0, tab(2)});
        check("R3 usb",  {26'b0, branch_ratio[29:24]}, {26'b0, tab(6)});
        check("R4 display", {26'b0, branch_ratio[35:30]}, 32'd7);
        check("R5 selects", {29'b0, pll_halve, usb_src_pll, aud_src_pll}, 32'b110);

        // R6 R7 PLL
        bus_write(12'h010, 32'h050C_0001);
        check("R7 active", {20'b0, pll_bypass, pll_ratio}, 32'd28);
        read_chk("R7 readback", 12'h010, 32'h050C_0001);
        bus_write(12'h010, 32'h0004_0001);
        check("R7 od1", {21'b0, pll_ratio}, 32'd4);
        bus_write(12'h010, 32'h050C_0003);
        check("R6 bypass", {20'b0, pll_bypass, pll_ratio}, 32'h801);
        read_chk("R6 stable", 12'h010, 32'h050C_0013);

        // R8
        bus_write(12'h028, 32'h0000_000F);
        check("R8 card", {27'b0, card_ratio}, 32'd16);

        // R10 undecoded offsets
        bus_write(12'h100, 32'hFFFF_FFFF);
        check("R10 err set", {31'b0, err_flag}, 32'h1);
        read_chk("R10 core untouched", 12'h000, 32'h10C7_2F49);
        read_chk("R10 undecoded read", 12'h104, 32'h0);
        read_chk("R10 err reg", 12'h03C, 32'h1);
        bus_write(12'h03C, 32'h0);
        check("R10 err clear", {31'b0, err_flag}, 32'h0);

        // R11 strobe spacing
        gap(3, p); gap(3, p);
        check("R11 mem period", p, 32'd3);
        gap(1, p); gap(1, p);
        check("R11 bus period", p, 32'd6);
        bus_write(12'h000, 32'h0000_0000);
        gap(5, p); gap(5, p);
        check("R11 display zero", p, 32'd1);

        // R12 change waits for boundary
        bus_write(12'h000, 32'h0000_0003);
        gap(0, p); gap(0, p);
        check("R12 pre period", p, 32'd4);
        @(negedge clk);
        bus_write(12'h000, 32'h0000_0000);
        p = 0;
        do begin @(negedge clk); p++; end while (!branch_en[0]);
        check("R12 not shortened", p, 32'd2);
        gap(0, p);
        check("R12 new period", p, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule